// File: doc/BRIEF.md
# Windowed Watchdog Timer with Configuration Locks

This block guards a system against runaway software. A down-counter is loaded from a programmable timeout. It steps once for every prescaled tick of a slow clock, which reaches the block as a single-cycle enable pulse in the system clock domain. Software must prove it is alive by writing two 16-bit key values, in order, to a service register before the count runs out. In windowed mode the service must also arrive late enough: a correct key pair that comes while the count is still above the programmed window value is treated as a fault, in the same way as an expiry.

Each fault produces the programmed response. The response can be a reset request, an interrupt, or an interrupt on the first fault followed by a reset request if a second fault arrives before software has cleared the interrupt flag. Configuration can be frozen with a soft lock, which an unlock key write removes, or with a hard lock, which only a block reset removes. While the device sits in a low-power state, counting can optionally be suspended.

The block uses a small word-addressed register interface. Register indices: 0 control, 1 timeout, 2 window, 3 service, 4 lock, 5 status, 6 live count. A write takes effect at the clock edge on which the write strobe is high. Read data is combinational from the address.

Top module: `wdg_top`

## Requirements
- R1: After reset, register 0 reads 0 when ENABLE_AT_RESET is 0, register 1 reads DEF_TIMEOUT, register 4 reads 0, and `irq` and `rst_req` are low. While the enable bit (control bit 0) is 0, neither output rises, whatever the slow tick does.
- R2: The count clock is one prescaled tick for every P+1 slow-tick pulses, where P is control bits 8:4 (0 to 31). An expiry fires on the prescaled tick that takes the count from 1 (or 0) to timeout, so with the enable bit set the first expiry occurs after (P+1)·max(T,1) slow ticks. No count happens without slow-tick pulses.
- R3: Writing KEY_FIRST and then KEY_SECOND in the low 16 bits of two consecutive writes to register 3 services the block while it is enabled. Servicing reloads the count, readable in register 6, with the timeout value.
- R4: A write to register 3 that breaks the sequence gives no service and discards progress. Such a write is KEY_SECOND without a preceding KEY_FIRST, or any value other than KEY_SECOND right after KEY_FIRST.
- R5: With the window bit (control bit 1) set, a correct key pair completed while the count is greater than the window value (register 2) is a violation. It triggers the programmed response and reloads the count.
- R6: With the window bit set, a key pair completed while the count is less than or equal to the window value is an ordinary service and produces no response.
- R7: The response field is control bits 3:2. The value 0 sets `rst_req`, 1 sets the interrupt flag, 2 means interrupt then reset, and 3 behaves like 0. Once set, `rst_req` stays high until the block is reset.
- R8: In interrupt-then-reset mode, a fault while the interrupt flag is clear sets the flag and reloads the count. A fault while the flag is set raises `rst_req`. If the flag is cleared between faults, no reset request results.
- R9: `irq` shows the interrupt flag. Writing 1 to bit 0 of register 5 clears the flag; a set in the same cycle wins.
- R10: With control bit 9 set, the count holds while `lp_mode` is high and resumes when it falls.
- R11: Writing register 4 with bit 16 set raises the soft lock (register 4 bit 0). While a lock is held, writes to registers 0, 1 and 2 are ignored. Writing UNLOCK_KEY in the low 16 bits of register 4 clears the soft lock.
- R12: Writing register 4 with bit 17 set raises the hard lock (register 4 bit 1). It blocks the same writes as the soft lock and survives every unlock write until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per slow oscillator period |
| lp_mode | input | 1 | Device is in a low-power state |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Interrupt flag |
| rst_req | output | 1 | Sticky reset request |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, the prescaler variant present, the default keys, a default timeout of 0xFFFF, and counting disabled out of reset. Small timeouts are written at run time, and the slow tick is held high so that each system cycle carries one slow pulse. This makes every expiry time an exact cycle count, so the full divide range up to 32 and the timeout-of-zero case can be reached within a few dozen cycles. The window boundary, where the count equals the window value, and the two-fault reset path are reached the same way.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam int ADDR_W  = 3;
   localparam int PRESC_W = 5;

   // register indices
   localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
   localparam logic [ADDR_W-1:0] A_TIMEOUT = 3'd1;
   localparam logic [ADDR_W-1:0] A_WINDOW  = 3'd2;
   localparam logic [ADDR_W-1:0] A_SERVICE = 3'd3;
   localparam logic [ADDR_W-1:0] A_LOCK    = 3'd4;
   localparam logic [ADDR_W-1:0] A_STATUS  = 3'd5;
   localparam logic [ADDR_W-1:0] A_COUNT   = 3'd6;

   typedef enum logic [1:0] {
      RESP_RESET     = 2'd0,
      RESP_IRQ       = 2'd1,
      RESP_IRQ_RESET = 2'd2,
      RESP_RESET_ALT = 2'd3
   } resp_e;

   typedef struct packed {
      logic               lp_halt;
      logic [PRESC_W-1:0] presc;
      resp_e              resp;
      logic               win_en;
      logic               en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int PW      = 5,
   parameter bit USE_DIV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          slow_tick,
   input  logic [PW-1:0] div_m1,
   output logic          tick
);

   generate
      if (USE_DIV) begin : g_div
         logic [PW-1:0] pcnt_q;
         logic          hit;

         assign hit = (pcnt_q >= div_m1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pcnt_q <= '0;
            else if (!run)      pcnt_q <= '0;
            else if (slow_tick) pcnt_q <= hit ? '0 : pcnt_q + 1'b1;
         end

         assign tick = run && slow_tick && hit;
      end else begin : g_direct
         assign tick = run && slow_tick;
      end
   endgenerate

endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq #(
   parameter int            KW   = 16,
   parameter logic [KW-1:0] KEY1 = 16'hB00C,
   parameter logic [KW-1:0] KEY2 = 16'h4FF3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [KW-1:0] val,
   output logic          ok
);

   logic armed_q;

   // any write while armed ends the attempt, matched or not
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  armed_q <= 1'b0;
      else if (wr) armed_q <= !armed_q && (val == KEY1);
   end

   assign ok = wr && armed_q && (val == KEY2);

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int            DW          = 32,
   parameter int            CW          = 32,
   parameter int            KW          = 16,
   parameter logic [KW-1:0] UNLOCK      = 16'hD1A7,
   parameter logic [CW-1:0] DEF_TIMEOUT = 'hFFFF,
   parameter bit            EN_RST      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [CW-1:0]     cnt,
   input  logic              irq_flag,
   output ctrl_t             ctrl,
   output logic [CW-1:0]     tmo,
   output logic [CW-1:0]     win,
   output logic              soft_lock,
   output logic              hard_lock,
   output logic              svc_wr,
   output logic              stat_clr
);

   logic locked;
   assign locked = soft_lock || hard_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '{lp_halt: 1'b0, presc: '0, resp: RESP_RESET,
                        win_en: 1'b0, en: EN_RST};
         tmo       <= DEF_TIMEOUT;
         win       <= '0;
         soft_lock <= 1'b0;
         hard_lock <= 1'b0;
      end else if (wr) begin
         case (addr)
            A_CTRL:    if (!locked) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            A_TIMEOUT: if (!locked) tmo  <= wdata[CW-1:0];
            A_WINDOW:  if (!locked) win  <= wdata[CW-1:0];
            A_LOCK: begin
               if (wdata[KW-1:0] == UNLOCK) begin
                  if (!hard_lock) soft_lock <= 1'b0;
               end else begin
                  if (wdata[KW])   soft_lock <= 1'b1;
                  if (wdata[KW+1]) hard_lock <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign svc_wr   = wr && (addr == A_SERVICE);
   assign stat_clr = wr && (addr == A_STATUS) && wdata[0];

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL:    rdata[CTRL_W-1:0] = ctrl;
         A_TIMEOUT: rdata[CW-1:0]     = tmo;
         A_WINDOW:  rdata[CW-1:0]     = win;
         A_LOCK:    rdata[1:0]        = {hard_lock, soft_lock};
         A_STATUS:  rdata[0]          = irq_flag;
         A_COUNT:   rdata[CW-1:0]     = cnt;
         default:   ;
      endcase
   end

endmodule

// File: rtl/wdg_core.sv
module wdg_core
   import wdg_pkg::*;
#(
   parameter int            CW          = 32,
   parameter logic [CW-1:0] DEF_TIMEOUT = 'hFFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ctrl_t         ctrl,
   input  logic [CW-1:0] tmo,
   input  logic [CW-1:0] win,
   input  logic          tick,
   input  logic          svc_ok,
   input  logic          stat_clr,
   output logic [CW-1:0] cnt,
   output logic          irq_flag,
   output logic          rst_req
);

   logic expire, violate, good_svc, fault;
   logic flag_set, rst_set;

   assign expire   = ctrl.en && tick && (cnt <= CW'(1));
   assign violate  = ctrl.en && svc_ok && ctrl.win_en && (cnt > win);
   assign good_svc = ctrl.en && svc_ok && !violate;
   assign fault    = expire || violate;

   always_comb begin
      flag_set = 1'b0;
      rst_set  = 1'b0;
      if (fault) begin
         case (ctrl.resp)
            RESP_IRQ:       flag_set = 1'b1;
            RESP_IRQ_RESET: begin
               if (irq_flag) rst_set  = 1'b1;
               else          flag_set = 1'b1;
            end
            default:        rst_set = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= DEF_TIMEOUT;
         irq_flag <= 1'b0;
         rst_req  <= 1'b0;
      end else begin
         if (!ctrl.en || fault || good_svc) cnt <= tmo;
         else if (tick)                     cnt <= cnt - 1'b1;

         if (flag_set)      irq_flag <= 1'b1;
         else if (stat_clr) irq_flag <= 1'b0;

         if (rst_set) rst_req <= 1'b1;
      end
   end

endmodule

// File: rtl/wdg_top.sv
module wdg_top
   import wdg_pkg::*;
#(
   parameter int               CNT_W           = 32,
   parameter int               DATA_W          = 32,
   parameter int               KEY_W           = 16,
   parameter logic [KEY_W-1:0] KEY_FIRST       = 16'hB00C,
   parameter logic [KEY_W-1:0] KEY_SECOND      = 16'h4FF3,
   parameter logic [KEY_W-1:0] UNLOCK_KEY      = 16'hD1A7,
   parameter logic [CNT_W-1:0] DEF_TIMEOUT     = 'hFFFF,
   parameter bit               ENABLE_AT_RESET = 1'b0,
   parameter bit               USE_PRESCALER   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              lp_mode,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              rst_req
);

   // elaboration checks
   if (DATA_W < CNT_W) begin : g_chk_data
      $error("wdg_top: DATA_W must hold the full count");
   end
   if (DATA_W < KEY_W + 2 || DATA_W < CTRL_W) begin : g_chk_fields
      $error("wdg_top: DATA_W too narrow for key and lock fields");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("wdg_top: CNT_W must be at least 2");
   end
   if (KEY_FIRST == KEY_SECOND) begin : g_chk_keys
      $error("wdg_top: the two service keys must differ");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] tmo, win, cnt;
   logic             soft_lock, hard_lock;
   logic             svc_wr, stat_clr, svc_ok, tick, run, irq_flag;

   assign run = ctrl.en && !(ctrl.lp_halt && lp_mode);

   wdg_regs #(
      .DW(DATA_W), .CW(CNT_W), .KW(KEY_W), .UNLOCK(UNLOCK_KEY),
      .DEF_TIMEOUT(DEF_TIMEOUT), .EN_RST(ENABLE_AT_RESET)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .cnt(cnt), .irq_flag(irq_flag),
      .ctrl(ctrl), .tmo(tmo), .win(win), .soft_lock(soft_lock),
      .hard_lock(hard_lock), .svc_wr(svc_wr), .stat_clr(stat_clr)
   );

   wdg_prescaler #(.PW(PRESC_W), .USE_DIV(USE_PRESCALER)) i_presc (
      .clk(clk), .rst_n(rst_n), .run(run), .slow_tick(slow_tick),
      .div_m1(ctrl.presc), .tick(tick)
   );

   wdg_key_seq #(.KW(KEY_W), .KEY1(KEY_FIRST), .KEY2(KEY_SECOND)) i_keys (
      .clk(clk), .rst_n(rst_n), .wr(svc_wr),
      .val(bus_wdata[KEY_W-1:0]), .ok(svc_ok)
   );

   wdg_core #(.CW(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) i_core (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tmo(tmo), .win(win),
      .tick(tick), .svc_ok(svc_ok), .stat_clr(stat_clr), .cnt(cnt),
      .irq_flag(irq_flag), .rst_req(rst_req)
   );

   assign irq = irq_flag;

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq,
   input logic          rst_req,
   input logic          en,
   input logic [1:0]    resp,
   input logic          hard_lock,
   input logic [CW-1:0] tmo
);

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!$rose(irq) && !$rose(rst_req))); // R1

   AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req); // R7

   AST_IRQ_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_req) && ($past(resp) == 2'd2)) |-> $past(irq)); // R8

   AST_HARD_LOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      hard_lock |=> hard_lock); // R12

   AST_HARD_LOCK_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      hard_lock |=> $stable(tmo)); // R12

   AST_HARD_LOCK_EN: assert property (@(posedge clk) disable iff (!rst_n)
      hard_lock |=> $stable(en)); // R12

endmodule

bind wdg_top wdg_chk #(.CW(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .rst_req(rst_req), .en(ctrl.en),
   .resp(ctrl.resp), .hard_lock(hard_lock), .tmo(tmo)
);

// File: tb/test_wdg_top.sv
module test_wdg_top;

   localparam logic [15:0] K1 = 16'hB00C;
   localparam logic [15:0] K2 = 16'h4FF3;
   localparam logic [15:0] UK = 16'hD1A7;

   // {prescale, timeout, expected cycles to first expiry}
   localparam int NVEC = 6;
   localparam logic [32:0] VEC [NVEC] = '{
      {5'd0,  16'd5, 12'd5},
      {5'd3,  16'd4, 12'd16},
      {5'd31, 16'd2, 12'd64},
      {5'd1,  16'd1, 12'd2},
      {5'd2,  16'd0, 12'd3},
      {5'd7,  16'd3, 12'd24}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b1;
   logic        lp_mode = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, rst_req;

   int n_chk = 0;
   int n_err = 0;

   wdg_top i_wdg_top (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .lp_mode(lp_mode),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bus_wr = 1'b0; slow_tick = 1'b1; lp_mode = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   initial begin
      #4_000_000;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] rv;
      @(negedge clk);
      do_reset();

      // R1 reset state
      rd_reg(3'd0, rv); check("R1 ctrl reset", rv, 32'h0);
      rd_reg(3'd1, rv); check("R1 timeout reset", rv, 32'hFFFF);
      rd_reg(3'd4, rv); check("R1 lock reset", rv, 32'h0);
      check("R1 irq reset", {31'b0, irq}, 32'h0);
      check("R1 rst_req reset", {31'b0, rst_req}, 32'h0);
      wr_reg(3'd1, 32'd2);
      wait_cyc(40);
      check("R1 disabled irq", {31'b0, irq}, 32'h0);
      check("R1 disabled rst_req", {31'b0, rst_req}, 32'h0);

      // R2 table of prescale/timeout pairs, interrupt response
      for (int i = 0; i < NVEC; i++) begin
         logic [4:0]  p;
         logic [15:0] t;
         int          n;
         p = VEC[i][32:28];
         t = VEC[i][27:12];
         n = int'(VEC[i][11:0]);
         do_reset();
         wr_reg(3'd1, {16'b0, t});
         wr_reg(3'd0, (32'(p) << 4) | 32'h5);
         wait_cyc(n - 1);
         check("R2 no expiry before limit", {31'b0, irq}, 32'h0);
         wait_cyc(1);
         check("R2 expiry at limit", {31'b0, irq}, 32'h1);
      end

      // R2 no slow ticks, no counting
      do_reset();
      slow_tick = 1'b0;
      wr_reg(3'd1, 32'd10);
      wr_reg(3'd0, 32'h5);
      wait_cyc(6);
      rd_reg(3'd6, rv); check("R2 count held without slow tick", rv, 32'd10);
      slow_tick = 1'b1;

      // R7 reset response and stickiness
      do_reset();
      wr_reg(3'd1, 32'd3);
      wr_reg(3'd0, 32'h1);
      wait_cyc(2);
      check("R7 rst_req before expiry", {31'b0, rst_req}, 32'h0);
      wait_cyc(1);
      check("R7 rst_req at expiry", {31'b0, rst_req}, 32'h1);
      wait_cyc(5);
      check("R7 rst_req sticky", {31'b0, rst_req}, 32'h1);
      check("R7 no irq in reset mode", {31'b0, irq}, 32'h0);

      // R7 response code 3 acts as reset
      do_reset();
      wr_reg(3'd1, 32'd2);
      wr_reg(3'd0, 32'hD);
      wait_cyc(2);
      check("R7 code 3 resets", {31'b0, rst_req}, 32'h1);
      check("R7 code 3 no irq", {31'b0, irq}, 32'h0);

      // R3 / R4 key sequence
      do_reset();
      wr_reg(3'd1, 32'd20);
      wr_reg(3'd0, 32'h5);
      wr_reg(3'd3, {16'b0, K2});
      wr_reg(3'd3, {16'b0, K1});
      rd_reg(3'd6, rv); check("R4 second key alone no service", rv, 32'd18);
      wr_reg(3'd3, {16'b0, K2});
      rd_reg(3'd6, rv); check("R3 service reloads count", rv, 32'd20);
      wr_reg(3'd3, {16'b0, K1});
      wr_reg(3'd3, 32'h1234);
      wr_reg(3'd3, {16'b0, K2});
      rd_reg(3'd6, rv); check("R4 broken sequence no service", rv, 32'd17);
      check("R3 no irq after service", {31'b0, irq}, 32'h0);

      // R5 / R6 / R9 window mode
      do_reset();
      wr_reg(3'd1, 32'd20);
      wr_reg(3'd2, 32'd5);
      wr_reg(3'd0, 32'h7);
      wr_reg(3'd3, {16'b0, K1});
      wr_reg(3'd3, {16'b0, K2});
      check("R5 early service raises irq", {31'b0, irq}, 32'h1);
      rd_reg(3'd6, rv); check("R5 violation reloads", rv, 32'd20);
      wr_reg(3'd5, 32'h1);
      check("R9 status write clears irq", {31'b0, irq}, 32'h0);
      wait_cyc(13);
      wr_reg(3'd3, {16'b0, K1});
      wr_reg(3'd3, {16'b0, K2});
      check("R6 service at window value no irq", {31'b0, irq}, 32'h0);
      rd_reg(3'd6, rv); check("R6 service at window reloads", rv, 32'd20);

      // R8 interrupt then reset
      do_reset();
      wr_reg(3'd1, 32'd4);
      wr_reg(3'd0, 32'h9);
      wait_cyc(4);
      check("R8 first fault irq", {31'b0, irq}, 32'h1);
      check("R8 first fault no reset", {31'b0, rst_req}, 32'h0);
      wait_cyc(3);
      check("R8 reset not yet", {31'b0, rst_req}, 32'h0);
      wait_cyc(1);
      check("R8 second fault resets", {31'b0, rst_req}, 32'h1);

      // R8 flag cleared between faults
      do_reset();
      wr_reg(3'd1, 32'd4);
      wr_reg(3'd0, 32'h9);
      wait_cyc(4);
      wr_reg(3'd5, 32'h1);
      check("R9 clear before second fault", {31'b0, irq}, 32'h0);
      wait_cyc(3);
      check("R8 cleared flag set again", {31'b0, irq}, 32'h1);
      check("R8 cleared flag no reset", {31'b0, rst_req}, 32'h0);

      // R10 low-power halt
      do_reset();
      wr_reg(3'd1, 32'd10);
      lp_mode = 1'b1;
      wr_reg(3'd0, 32'h205);
      wait_cyc(5);
      rd_reg(3'd6, rv); check("R10 count held in low power", rv, 32'd10);
      lp_mode = 1'b0;
      wait_cyc(3);
      rd_reg(3'd6, rv); check("R10 count resumes", rv, 32'd7);

      // R11 soft lock
      do_reset();
      wr_reg(3'd4, 32'h1_0000);
      rd_reg(3'd4, rv); check("R11 soft lock set", rv, 32'h1);
      wr_reg(3'd1, 32'h55);
      rd_reg(3'd1, rv); check("R11 locked timeout unchanged", rv, 32'hFFFF);
      wr_reg(3'd4, {16'b0, UK});
      rd_reg(3'd4, rv); check("R11 unlock clears soft lock", rv, 32'h0);
      wr_reg(3'd1, 32'h55);
      rd_reg(3'd1, rv); check("R11 unlocked timeout written", rv, 32'h55);

      // R12 hard lock
      do_reset();
      wr_reg(3'd4, 32'h2_0000);
      wr_reg(3'd4, {16'b0, UK});
      rd_reg(3'd4, rv); check("R12 hard lock survives unlock", rv, 32'h2);
      wr_reg(3'd0, 32'h1);
      rd_reg(3'd0, rv); check("R12 ctrl write ignored", rv, 32'h0);
      wr_reg(3'd1, 32'h7);
      rd_reg(3'd1, rv); check("R12 timeout write ignored", rv, 32'hFFFF);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule